// File: doc/BRIEF.md
# Eight-Channel Serial Register Decoder and Interrupt Vector Former

This block sits between a 16-bit bus and a bank of eight serial channels. It inspects each bus address and decides whether the address belongs to the bank. For a hit it reports which channel is addressed, which of that channel's four registers is meant, and which byte lanes take part. The bank's window comes from a switch-set base field. The window is a run of eight contiguous 8-byte channel slots in the top eighth of the address space.

The same block forms the interrupt vector for the channel that wins service. Requests come from receive and transmit sources on every channel. The lowest channel wins, and on a tie within one channel, receive wins over transmit. The vector word carries a switch-set base field, the channel number and a direction bit.

A console switch moves channel 7 to a fixed address window and a fixed vector pair. In that case the normal slot for channel 7 stays silent. Once the interrupt logic grants a request, the vector is frozen until the acknowledge cycle ends.

Top module: `sio_regmap_vec`

## Requirements
- R1: After reset, `hit`, `chan_sel`, `reg_sel`, `lane_en`, `vec_out`, `irq_pend` and `irq_hold` all read zero.
- R2: When `addr_valid` is high, `bus_addr[15:13]` is 111 and `bus_addr[12:6]` equals `base_sw`, the next cycle shows `hit`=1, `chan_sel`=`bus_addr[5:3]` and `reg_sel`=`bus_addr[2:1]`. The register codes are 00 receive status, 01 receive data, 10 transmit status and 11 transmit data.
- R3: When `addr_valid` is low, `bus_addr[15:13]` is not 111, or no window matches, the next cycle shows `hit`=0 with `chan_sel`, `reg_sel` and `lane_en` all zero.
- R4: A word access (`acc_byte`=0) hits only at an even address and gives `lane_en`=11. A byte access gives `lane_en`=01 when `bus_addr[0]`=0 and 10 when it is 1.
- R5: With `console_en`=1, any address from 0xFF70 to 0xFF77 (octal 177560–177567) hits as channel 7, with `reg_sel`=`bus_addr[2:1]`, whatever the value of `base_sw`.
- R6: With `console_en`=1, the channel-7 slot of the base window does not hit. With `console_en`=0, the console addresses hit only if the base window covers them.
- R7: When the console window and a base slot cover the same address, the console decode wins and reports channel 7.
- R8: One cycle after the requests are applied, `vec_out` equals {`vec_sw`, channel, dir, 00} zero-extended to 16 bits, where dir is 0 for receive and 1 for transmit. With no request pending and no hold active, `vec_out` is zero.
- R9: Among pending requests, the lowest channel wins. Within one channel, receive beats transmit.
- R10: With `console_en`=1 and channel 7 winning, `vec_out` is octal 060 for receive and octal 064 for transmit.
- R11: `irq_grant` while a request is pending sets `irq_hold` on the next cycle, and `vec_out` then stays fixed. A cycle with `irq_ack` clears `irq_hold` on the next cycle. After that, `vec_out` follows the requests again. A grant with no request pending has no effect.
- R12: `irq_pend` is the registered OR of every receive and transmit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Bus address is being presented |
| acc_byte | input | 1 | 1 for a byte access, 0 for a word access |
| bus_addr | input | 16 | Bus address |
| base_sw | input | 7 | Base-window switch field (address bits 12:6) |
| vec_sw | input | 3 | Base-vector switch field (vector bits 8:6) |
| console_en | input | 1 | Console remap of channel 7 |
| rx_req | input | 8 | Receive interrupt requests, one per channel |
| tx_req | input | 8 | Transmit interrupt requests, one per channel |
| irq_grant | input | 1 | Interrupt service granted |
| irq_ack | input | 1 | Acknowledge cycle completing |
| hit | output | 1 | Address belongs to the bank |
| chan_sel | output | 3 | Addressed channel |
| reg_sel | output | 2 | Addressed register |
| lane_en | output | 2 | Byte lanes enabled (bit 0 low byte) |
| irq_pend | output | 1 | Some request pending |
| irq_hold | output | 1 | Vector frozen for an acknowledge |
| vec_out | output | 16 | Interrupt vector word |

## Verification
The assertions assume that the switch fields and `console_en` stay constant while an access or an interrupt is in flight. The stimulus changes them only between checks, in cycles where no grant is held. The assertions also assume that `irq_ack` arrives only while a hold is active. The bench raises it only after it has seen `irq_hold` set. Grant is a single-cycle pulse, and request vectors are changed only at the falling edge of the clock.

// File: rtl/sio_map_pkg.sv
package sio_map_pkg;

    typedef enum logic [1:0] {
        REG_RX_STAT = 2'b00,
        REG_RX_DATA = 2'b01,
        REG_TX_STAT = 2'b10,
        REG_TX_DATA = 2'b11
    } reg_code_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] chan;
        logic [1:0] rsel;
        logic [1:0] lanes;
    } dec_res_t;

    typedef struct packed {
        logic       found;
        logic [2:0] chan;
        logic       dir_tx;
    } pick_res_t;

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_map_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CH_W     = 3,
    parameter int RG_W     = 2,
    parameter int BASE_W   = 7,
    parameter logic [15:0] CON_ADDR = 16'hFF70
) (
    input  logic              addr_valid,
    input  logic              acc_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BASE_W-1:0] base_sw,
    input  logic              console_en,
    output dec_res_t          res
);
    localparam int SLOT_LO = RG_W + 1;
    localparam int BASE_LO = SLOT_LO + CH_W;
    localparam int TOP_LO  = BASE_LO + BASE_W;
    localparam int TOP_W   = ADDR_W - TOP_LO;
    localparam logic [CH_W-1:0] CON_CH = '1;
    localparam logic [ADDR_W-SLOT_LO-1:0] CON_TAG = CON_ADDR[ADDR_W-1:SLOT_LO];

    logic top_ok, base_ok, con_ok, align_ok, slot_blk;
    logic [CH_W-1:0] slot_ch;

    always_comb begin
        slot_ch  = bus_addr[BASE_LO-1:SLOT_LO];
        top_ok   = (bus_addr[ADDR_W-1:TOP_LO] == {TOP_W{1'b1}});
        base_ok  = top_ok && (bus_addr[TOP_LO-1:BASE_LO] == base_sw);
        con_ok   = console_en && (bus_addr[ADDR_W-1:SLOT_LO] == CON_TAG);
        slot_blk = console_en && (slot_ch == CON_CH);
        align_ok = acc_byte || !bus_addr[0];
        res      = '0;
        if (addr_valid && align_ok) begin
            if (con_ok) begin
                res.hit  = 1'b1;
                res.chan = CON_CH;
                res.rsel = bus_addr[RG_W:1];
            end else if (base_ok && !slot_blk) begin
                res.hit  = 1'b1;
                res.chan = slot_ch;
                res.rsel = bus_addr[RG_W:1];
            end
            if (res.hit) begin
                if (!acc_byte)       res.lanes = 2'b11;
                else if (bus_addr[0]) res.lanes = 2'b10;
                else                  res.lanes = 2'b01;
            end
        end
    end
endmodule

// File: rtl/sio_irq_pick.sv
module sio_irq_pick
    import sio_map_pkg::*;
#(
    parameter int NCHAN = 8,
    parameter int CH_W  = 3
) (
    input  logic [NCHAN-1:0] rx_req,
    input  logic [NCHAN-1:0] tx_req,
    output pick_res_t        res
);
    always_comb begin
        res = '0;
        for (int i = NCHAN - 1; i >= 0; i--) begin
            if (tx_req[i]) begin
                res.found  = 1'b1;
                res.chan   = CH_W'(i);
                res.dir_tx = 1'b1;
            end
            if (rx_req[i]) begin
                res.found  = 1'b1;
                res.chan   = CH_W'(i);
                res.dir_tx = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_vec_form.sv
module sio_vec_form
    import sio_map_pkg::*;
#(
    parameter int VEC_W  = 16,
    parameter int VSW_W  = 3,
    parameter int CH_W   = 3,
    parameter logic [15:0] CON_VEC = 16'o060
) (
    input  pick_res_t        pick,
    input  logic [VSW_W-1:0] vec_sw,
    input  logic             console_en,
    output logic [VEC_W-1:0] vec
);
    localparam int FIELD_W = VSW_W + CH_W + 3;
    localparam logic [CH_W-1:0] CON_CH = '1;

    logic [FIELD_W-1:0] field;

    always_comb begin
        field = {vec_sw, pick.chan, pick.dir_tx, 2'b00};
        vec   = '0;
        if (pick.found) begin
            if (console_en && pick.chan == CON_CH)
                vec = CON_VEC[VEC_W-1:0] | (VEC_W'(pick.dir_tx) << 2);
            else
                vec = VEC_W'(field);
        end
    end
endmodule

// File: rtl/sio_regmap_vec.sv
module sio_regmap_vec
    import sio_map_pkg::*;
#(
    parameter int NCHAN  = 8,
    parameter int ADDR_W = 16,
    parameter int NREG   = 4,
    parameter int VEC_W  = 16,
    parameter int VSW_W  = 3,
    parameter logic [15:0] CON_ADDR = 16'o177560,
    parameter logic [15:0] CON_VEC  = 16'o060
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic              acc_byte,
    input  logic [15:0]       bus_addr,
    input  logic [6:0]        base_sw,
    input  logic [2:0]        vec_sw,
    input  logic              console_en,
    input  logic [7:0]        rx_req,
    input  logic [7:0]        tx_req,
    input  logic              irq_grant,
    input  logic              irq_ack,
    output logic              hit,
    output logic [2:0]        chan_sel,
    output logic [1:0]        reg_sel,
    output logic [1:0]        lane_en,
    output logic              irq_pend,
    output logic              irq_hold,
    output logic [15:0]       vec_out
);
    localparam int CH_W   = $clog2(NCHAN);
    localparam int RG_W   = $clog2(NREG);
    localparam int BASE_W = ADDR_W - 3 - CH_W - RG_W - 1;

    typedef struct packed {
        dec_res_t         dec;
        logic             pend;
        logic             held;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t    st_d, st_q;
    dec_res_t  dec_now;
    pick_res_t pick_now;
    logic [VEC_W-1:0] vec_now;

    sio_addr_decode #(
        .ADDR_W(ADDR_W), .CH_W(CH_W), .RG_W(RG_W),
        .BASE_W(BASE_W), .CON_ADDR(CON_ADDR)
    ) u_dec (
        .addr_valid(addr_valid), .acc_byte(acc_byte), .bus_addr(bus_addr),
        .base_sw(base_sw), .console_en(console_en), .res(dec_now)
    );

    sio_irq_pick #(.NCHAN(NCHAN), .CH_W(CH_W)) u_pick (
        .rx_req(rx_req), .tx_req(tx_req), .res(pick_now)
    );

    sio_vec_form #(
        .VEC_W(VEC_W), .VSW_W(VSW_W), .CH_W(CH_W), .CON_VEC(CON_VEC)
    ) u_vec (
        .pick(pick_now), .vec_sw(vec_sw), .console_en(console_en), .vec(vec_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.dec  = dec_now;
        st_d.pend = pick_now.found;
        if (st_q.held) begin
            st_d.held = !irq_ack;
        end else begin
            st_d.vec  = vec_now;
            st_d.held = irq_grant && pick_now.found;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit      = st_q.dec.hit;
    assign chan_sel = st_q.dec.chan;
    assign reg_sel  = st_q.dec.rsel;
    assign lane_en  = st_q.dec.lanes;
    assign irq_pend = st_q.pend;
    assign irq_hold = st_q.held;
    assign vec_out  = st_q.vec;
endmodule

// File: rtl/sio_regmap_vec_chk.sv
module sio_regmap_vec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_valid,
    input logic        acc_byte,
    input logic [15:0] bus_addr,
    input logic [6:0]  base_sw,
    input logic        console_en,
    input logic [7:0]  rx_req,
    input logic [7:0]  tx_req,
    input logic        irq_ack,
    input logic        hit,
    input logic [2:0]  chan_sel,
    input logic [1:0]  lane_en,
    input logic        irq_pend,
    input logic        irq_hold,
    input logic [15:0] vec_out
);
    localparam logic [12:0] CON_TAG = 13'h1FEE;

    p_top_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && bus_addr[15:13] != 3'b111) |=> !hit);

    p_odd_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !acc_byte && bus_addr[0]) |=> !hit);

    p_lane_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (lane_en != 2'b00));

    p_console_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && console_en && bus_addr[15:3] == CON_TAG &&
         (acc_byte || !bus_addr[0])) |=> (hit && chan_sel == 3'd7));

    p_slot_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && console_en && bus_addr[15:6] == {3'b111, base_sw} &&
         bus_addr[5:3] == 3'b111 && bus_addr[15:3] != CON_TAG) |=> !hit);

    p_ch0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req[0] && !irq_hold) |=> (vec_out[5:2] == 4'b0000));

    p_vec_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hold && !irq_ack) |=> (irq_hold && $stable(vec_out)));

    p_hold_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hold && irq_ack) |=> !irq_hold);

    p_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_req | tx_req) != 8'h00) |=> irq_pend);
endmodule

bind sio_regmap_vec sio_regmap_vec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .acc_byte(acc_byte),
    .bus_addr(bus_addr), .base_sw(base_sw), .console_en(console_en),
    .rx_req(rx_req), .tx_req(tx_req), .irq_ack(irq_ack), .hit(hit),
    .chan_sel(chan_sel), .lane_en(lane_en), .irq_pend(irq_pend),
    .irq_hold(irq_hold), .vec_out(vec_out)
);

// File: tb/tb_sio_regmap_vec.sv
module tb_sio_regmap_vec;
    localparam int CLK_NS = 10;
    localparam int NVEC   = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_valid = 1'b0, acc_byte = 1'b0, console_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [6:0]  base_sw = 7'h75;
    logic [2:0]  vec_sw = 3'd3;
    logic [7:0]  rx_req = '0, tx_req = '0;
    logic irq_grant = 1'b0, irq_ack = 1'b0;
    logic hit, irq_pend, irq_hold;
    logic [2:0] chan_sel;
    logic [1:0] reg_sel, lane_en;
    logic [15:0] vec_out;

    int n_chk = 0, n_bad = 0;

    // stimulus {console_en, base_sw, acc_byte, bus_addr}; expected {hit, chan, reg, lanes}
    localparam logic [24:0] STIM [NVEC] = '{
        {1'b0, 7'h75, 1'b0, 16'hFD40}, {1'b0, 7'h75, 1'b0, 16'hFD4A},
        {1'b0, 7'h75, 1'b1, 16'hFD55}, {1'b0, 7'h75, 1'b1, 16'hFD5E},
        {1'b0, 7'h75, 1'b0, 16'hFD41}, {1'b0, 7'h75, 1'b0, 16'hFD78},
        {1'b1, 7'h75, 1'b0, 16'hFD78}, {1'b1, 7'h75, 1'b0, 16'hFF70},
        {1'b1, 7'h75, 1'b0, 16'hFF76}, {1'b0, 7'h75, 1'b0, 16'hFF70},
        {1'b0, 7'h7D, 1'b0, 16'hFF70}, {1'b1, 7'h7D, 1'b0, 16'hFF74},
        {1'b0, 7'h75, 1'b0, 16'hDD40}, {1'b0, 7'h74, 1'b0, 16'hFD40},
        {1'b1, 7'h7D, 1'b0, 16'hFF78}
    };
    localparam logic [7:0] EXPV [NVEC] = '{
        {1'b1, 3'd0, 2'd0, 2'b11}, {1'b1, 3'd1, 2'd1, 2'b11},
        {1'b1, 3'd2, 2'd2, 2'b10}, {1'b1, 3'd3, 2'd3, 2'b01},
        8'h00,                     {1'b1, 3'd7, 2'd0, 2'b11},
        8'h00,                     {1'b1, 3'd7, 2'd0, 2'b11},
        {1'b1, 3'd7, 2'd3, 2'b11}, 8'h00,
        {1'b1, 3'd6, 2'd0, 2'b11}, {1'b1, 3'd7, 2'd2, 2'b11},
        8'h00, 8'h00, 8'h00
    };
    localparam string VTAG [NVEC] = '{
        "R2", "R2", "R4", "R4", "R4", "R6", "R6", "R5",
        "R5", "R6", "R6", "R7", "R3", "R3", "R6"
    };

    sio_regmap_vec dut (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .acc_byte(acc_byte),
        .bus_addr(bus_addr), .base_sw(base_sw), .vec_sw(vec_sw),
        .console_en(console_en), .rx_req(rx_req), .tx_req(tx_req),
        .irq_grant(irq_grant), .irq_ack(irq_ack), .hit(hit), .chan_sel(chan_sel),
        .reg_sel(reg_sel), .lane_en(lane_en), .irq_pend(irq_pend),
        .irq_hold(irq_hold), .vec_out(vec_out)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic vec_case(input string tag, input logic [7:0] rx, input logic [7:0] tx,
                            input logic con, input logic [15:0] exp);
        rx_req = rx; tx_req = tx; console_en = con;
        step();
        check(tag, 32'(vec_out), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {22'd0, hit, chan_sel, reg_sel, lane_en, irq_pend, irq_hold},
              32'd0);
        check("R1", 32'(vec_out), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {console_en, base_sw, acc_byte, bus_addr} = STIM[i];
            addr_valid = 1'b1;
            step();
            check(VTAG[i], {24'd0, hit, chan_sel, reg_sel, lane_en}, 32'(EXPV[i]));
        end

        // R3: no strobe, otherwise matching address
        console_en = 1'b0; base_sw = 7'h75; acc_byte = 1'b0;
        bus_addr = 16'hFD40; addr_valid = 1'b0;
        step();
        check("R3", {31'd0, hit}, 32'd0);

        // R8 / R9 / R10 / R12 vectors, base vector field 3 (octal 300)
        vec_sw = 3'd3;
        vec_case("R8", 8'h00, 8'h00, 1'b0, 16'h0000);
        check("R12", {31'd0, irq_pend}, 32'd0);
        vec_case("R8", 8'h08, 8'h00, 1'b0, 16'h00D8);
        check("R12", {31'd0, irq_pend}, 32'd1);
        vec_case("R9", 8'h20, 8'h04, 1'b0, 16'h00D4);
        vec_case("R9", 8'h10, 8'h10, 1'b0, 16'h00E0);
        vec_case("R8", 8'h80, 8'h00, 1'b0, 16'h00F8);
        vec_case("R10", 8'h80, 8'h00, 1'b1, 16'h0030);
        vec_case("R10", 8'h00, 8'h80, 1'b1, 16'h0034);
        vec_case("R12", 8'h00, 8'h40, 1'b0, 16'h00F4);
        check("R12", {31'd0, irq_pend}, 32'd1);

        // R11 grant with nothing pending is ignored
        rx_req = '0; tx_req = '0; irq_grant = 1'b1;
        step();
        irq_grant = 1'b0;
        check("R11", {31'd0, irq_hold}, 32'd0);

        // R11 hold and release
        rx_req = 8'h02; irq_grant = 1'b1;
        step();
        irq_grant = 1'b0;
        check("R11", {31'd0, irq_hold}, 32'd1);
        check("R11", 32'(vec_out), 32'h00C8);
        rx_req = 8'h01;
        step();
        check("R11", 32'(vec_out), 32'h00C8);
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        check("R11", {31'd0, irq_hold}, 32'd0);
        step();
        check("R11", 32'(vec_out), 32'h00C0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule